// File: doc/BRIEF.md
# Configurable Four-Sided Routing Switch

This block is one switching point of a virtual routing fabric built from ordinary logic on an FPGA. It has four sides (north, east, south, west). Each side has an n-bit input track and an n-bit output track. Every output track is driven by its own multiplexer. That multiplexer picks one of the three other sides' inputs, or drives all zeros, as set by a two-bit select field. An output can never be connected back to the input on its own side. Any topology the fabric needs is built by choosing, per output, which neighbour feeds it.

The select fields form one configuration word that is loaded serially, one bit per clock, through a shift chain. The selects in use change only when a load is complete. Registering of each output is chosen at elaboration time through a per-side mask. Registered outputs break combinational loops when routes form cycles through several switches, and they bound the mux-chain delay. Unregistered outputs pass their selection straight through.

Top module: `sbox_switch`

## Requirements
- R1: Sides are numbered north=0, east=1, south=2, west=3. For output side s, select code 0 drives all zeros, and code c (1 to 3) drives the input of side (s+c) mod 4. An output therefore never takes its own side's input.
- R2: On each rising edge with cfg_en high, cfg_din enters bit 0 of an 8-bit chain and the existing bits move up by one. Bits [2s+1:2s] of the completed word are the select for side s, so the first bit shifted in lands in bit 7.
- R3: The selects in use do not change while cfg_en is high. They take the chain contents at the first rising edge where cfg_en is low after having been high.
- R4: An output whose bit in REG_MASK is set shows, one clock later, the value selected at the previous rising edge.
- R5: An output whose bit in REG_MASK is clear follows its selected input within the same cycle.
- R6: A synchronous active-high reset sets every select to code 0 and clears all output registers, so every output reads zero afterwards regardless of the inputs.
- R7: All TRACK_W bits of a selected track reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| n_in | input | TRACK_W | North input track |
| e_in | input | TRACK_W | East input track |
| s_in | input | TRACK_W | South input track |
| w_in | input | TRACK_W | West input track |
| n_out | output | TRACK_W | North output track |
| e_out | output | TRACK_W | East output track |
| s_out | output | TRACK_W | South output track |
| w_out | output | TRACK_W | West output track |

## Verification
Inputs change at the falling edge. Unregistered outputs are compared about 1 ns later in that same half cycle. At that moment the registered outputs must still hold the previous value. The scoreboard then checks all four outputs 1 ns after the next rising edge, when the registered ones are due.

A new configuration is checked three times. Midway through shifting, every output must still reflect the old selects. Just after the load edge, unregistered outputs must show the new selects while registered outputs still show the old value. One edge later, all outputs must follow the new selects.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int NSIDES = 4;
  localparam int SEL_W  = 2;
  localparam int CFG_W  = NSIDES * SEL_W;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam logic [SEL_W-1:0] SEL_ZERO = '0;
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic [CFG_W-1:0] sel_word
);
  logic [CFG_W-1:0] shreg;
  logic             en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      en_d     <= 1'b0;
      sel_word <= '0;
    end else begin
      en_d <= cfg_en;
      if (cfg_en)
        shreg <= {shreg[CFG_W-2:0], cfg_din};
      // commit only once the shifting burst has ended
      if (!cfg_en && en_d)
        sel_word <= shreg;
    end
  end
endmodule

// File: rtl/sbox_sel_mux.sv
module sbox_sel_mux
  import sbox_pkg::*;
#(
  parameter int TRACK_W = 8,
  parameter int SIDE    = 0
) (
  input  logic [NSIDES-1:0][TRACK_W-1:0] tracks_in,
  input  logic [SEL_W-1:0]               sel,
  output logic [TRACK_W-1:0]             track_out
);
  logic [SEL_W-1:0] src;

  // code c picks the side c steps further round; wraps modulo 4
  assign src = SEL_W'(SIDE) + sel;

  always_comb begin
    if (sel == SEL_ZERO) track_out = '0;
    else                 track_out = tracks_in[src];
  end
endmodule

// File: rtl/sbox_switch.sv
module sbox_switch
  import sbox_pkg::*;
#(
  parameter int                TRACK_W  = 8,
  parameter logic [NSIDES-1:0] REG_MASK = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_din,
  input  logic [TRACK_W-1:0] n_in,
  input  logic [TRACK_W-1:0] e_in,
  input  logic [TRACK_W-1:0] s_in,
  input  logic [TRACK_W-1:0] w_in,
  output logic [TRACK_W-1:0] n_out,
  output logic [TRACK_W-1:0] e_out,
  output logic [TRACK_W-1:0] s_out,
  output logic [TRACK_W-1:0] w_out
);
  logic [NSIDES-1:0][TRACK_W-1:0] trk_in;
  logic [TRACK_W-1:0]             trk_out [NSIDES];
  logic [CFG_W-1:0]               sel_word;

  assign trk_in = {w_in, s_in, e_in, n_in};

  sbox_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .sel_word (sel_word)
  );

  for (genvar i = 0; i < NSIDES; i++) begin : g_side
    logic [TRACK_W-1:0] mux_val;

    sbox_sel_mux #(.TRACK_W(TRACK_W), .SIDE(i)) u_mux (
      .tracks_in (trk_in),
      .sel       (sel_word[SEL_W*i +: SEL_W]),
      .track_out (mux_val)
    );

    if (REG_MASK[i]) begin : g_reg
      logic [TRACK_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= mux_val;
      end
      assign trk_out[i] = q;
    end else begin : g_comb
      assign trk_out[i] = mux_val;
    end
  end

  assign n_out = trk_out[SIDE_N];
  assign e_out = trk_out[SIDE_E];
  assign s_out = trk_out[SIDE_S];
  assign w_out = trk_out[SIDE_W];
endmodule

// File: rtl/sbox_switch_chk.sv
module sbox_switch_chk
  import sbox_pkg::*;
#(
  parameter int                TRACK_W  = 8,
  parameter logic [NSIDES-1:0] REG_MASK = 4'b0011
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic [TRACK_W-1:0] n_in,
  input logic [TRACK_W-1:0] e_in,
  input logic [TRACK_W-1:0] s_in,
  input logic [TRACK_W-1:0] w_in,
  input logic [TRACK_W-1:0] n_out,
  input logic [TRACK_W-1:0] e_out,
  input logic [TRACK_W-1:0] s_out,
  input logic [TRACK_W-1:0] w_out,
  input logic [CFG_W-1:0]   sel_word
);
  logic [NSIDES-1:0][TRACK_W-1:0] ins, outs;
  assign ins  = {w_in, s_in, e_in, n_in};
  assign outs = {w_out, s_out, e_out, n_out};

  // R3: no select change at the edge after one where shifting was active
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(sel_word));

  for (genvar i = 0; i < NSIDES; i++) begin : g_chk
    localparam int OPP = (i + 2) % NSIDES;
    localparam int NXT = (i + 1) % NSIDES;

    if (REG_MASK[i]) begin : g_reg
      // R4 with R1: opposite side appears one clock later
      p_reg_delay_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel_word[SEL_W*i +: SEL_W]) == 2'd2)
          |-> outs[i] == $past(ins[OPP]));
      // R6: registers empty right after reset
      p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> outs[i] == '0);
    end else begin : g_comb
      // R5 with R1: next side passes straight through
      p_comb_follow_r5: assert property (@(posedge clk) disable iff (rst)
        sel_word[SEL_W*i +: SEL_W] == 2'd1 |-> outs[i] == ins[NXT]);
      // R1: code 0 drives zeros
      p_zero_code_r1: assert property (@(posedge clk) disable iff (rst)
        sel_word[SEL_W*i +: SEL_W] == SEL_ZERO |-> outs[i] == '0);
    end
  end
endmodule

bind sbox_switch sbox_switch_chk #(.TRACK_W(TRACK_W), .REG_MASK(REG_MASK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .n_in     (n_in),
  .e_in     (e_in),
  .s_in     (s_in),
  .w_in     (w_in),
  .n_out    (n_out),
  .e_out    (e_out),
  .s_out    (s_out),
  .w_out    (w_out),
  .sel_word (sel_word)
);

// File: tb/test_sbox_switch.sv
module test_sbox_switch;
  localparam int         TW    = 8;
  localparam logic [3:0] RMASK = 4'b0011;

  typedef struct packed {
    logic [3:0][TW-1:0] exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_din = 1'b0;
  logic [TW-1:0] tin  [4];
  logic [TW-1:0] tout [4];

  logic [7:0]         cur_cfg = '0;
  logic [3:0][TW-1:0] last_exp = '0;
  item_t              sbq [$];
  int                 n_chk = 0;
  int                 n_bad = 0;
  bit                 done = 1'b0;

  always #2 clk = ~clk;

  sbox_switch #(.TRACK_W(TW), .REG_MASK(RMASK)) i_sbox_switch (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .n_in(tin[0]), .e_in(tin[1]), .s_in(tin[2]), .w_in(tin[3]),
    .n_out(tout[0]), .e_out(tout[1]), .s_out(tout[2]), .w_out(tout[3])
  );

  task automatic chk(input string req, input int side, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s side %0d: actual %h expected %h", req, side, act, exp);
    end
  endtask

  // R1: code 0 -> zeros, code c -> input of side (s+c) mod 4
  function automatic logic [TW-1:0] model(input int s, input logic [7:0] cfg);
    logic [1:0] c;
    c = cfg[2*s +: 2];
    if (c == 2'd0) return '0;
    return tin[(s + int'(c)) % 4];
  endfunction

  function automatic logic [3:0][TW-1:0] model_all(input logic [7:0] cfg);
    logic [3:0][TW-1:0] r;
    for (int s = 0; s < 4; s++) r[s] = model(s, cfg);
    return r;
  endfunction

  // monitor: registered results are due one edge after the drive
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        for (int s = 0; s < 4; s++) chk("R1/R4/R5/R7 scoreboard", s, tout[s], it.exp[s]);
      end
    end
  end

  task automatic apply(input logic [TW-1:0] a, b, c, d);
    item_t it;
    @(negedge clk);
    tin[0] = a; tin[1] = b; tin[2] = c; tin[3] = d;
    #1;
    for (int s = 0; s < 4; s++) begin
      if (RMASK[s]) chk("R4 holds previous until edge", s, tout[s], last_exp[s]);
      else          chk("R5 same-cycle follow", s, tout[s], model(s, cur_cfg));
    end
    it.exp   = model_all(cur_cfg);
    last_exp = it.exp;
    sbq.push_back(it);
  endtask

  task automatic load_cfg(input logic [7:0] word);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_din = word[b];
      if (b == 3) begin
        #1;
        for (int s = 0; s < 4; s++) chk("R3 old selects while shifting", s, tout[s], last_exp[s]);
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++) begin
      if (RMASK[s]) chk("R3/R4 registered still old at load edge", s, tout[s], last_exp[s]);
      else          chk("R2/R3 new select after load edge", s, tout[s], model(s, word));
    end
    cur_cfg = word;
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++) chk("R2 new select everywhere", s, tout[s], model(s, word));
    last_exp = model_all(word);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    cur_cfg = '0; last_exp = '0;
    #1;
    for (int s = 0; s < 4; s++) chk("R6 zero after reset", s, tout[s], '0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) tin[s] = 8'h3C;
    repeat (3) @(negedge clk);
    do_reset();
    apply(8'h11, 8'h22, 8'h33, 8'h44);           // R1 all code 0
    // N:1->E, E:2->W, S:3->E, W:1->N
    load_cfg(8'b01_11_10_01);
    apply(8'hA5, 8'h5A, 8'hFF, 8'h00);           // R7 bit patterns
    apply(8'h01, 8'h80, 8'h7E, 8'hC3);
    apply(8'hFF, 8'hFF, 8'h00, 8'h00);
    // N:3->W, E:1->S, S:2->N, W:0 zero
    load_cfg(8'b00_10_01_11);
    apply(8'h12, 8'h34, 8'h56, 8'h78);
    apply(8'hF0, 8'h0F, 8'hAA, 8'h55);
    // all opposite
    load_cfg(8'b10_10_10_10);
    apply(8'h81, 8'h42, 8'h24, 8'h18);
    apply(8'h00, 8'hFF, 8'h99, 8'h66);
    do_reset();                                  // R6 config cleared
    apply(8'hDE, 8'hAD, 8'hBE, 8'hEF);
    apply(8'h01, 8'h02, 8'h04, 8'h08);
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule